// File: doc/BRIEF.md
# Register Rename Stage with FIFO Free Pool

This block sits between decode and scheduling. It takes one instruction per cycle and rewrites its register names. Each of the two source names is looked up in a table that holds the current architectural-to-physical binding. An instruction that writes a register gets a fresh physical register from a pool of unused ones, and that register becomes the new binding for its destination. Instructions that write nothing, such as stores, take nothing from the pool. The renamed instruction leaves one cycle later. It also carries the physical register the destination was bound to before, so that later logic can hand that register back once the value has no more readers.

Freed registers come back through a release port and join the tail of the pool. The pool hands registers out strictly from its head. When the pool is empty, an instruction with a destination is held off through the input handshake until a register comes back. A release and an allocation can happen in the same cycle.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i is bound to physical register i. The pool holds physical registers 8 to 15, in rising order from head to tail. `in_ready` is 1 and `out_valid` is 0.
- R2: A source name is translated to the physical register most recently allocated for it, or to its reset binding if no instruction has written it yet.
- R3: An instruction that reads and writes the same architectural register reads the binding that was current before it was renamed.
- R4: Each accepted instruction with `in_has_dst`=1 takes the register at the head of the pool as `out_dst_p`. That register becomes the new binding of `in_dst`, and it always differs from the previous binding.
- R5: `out_old_p` carries the binding that `in_dst` had just before the instruction was renamed.
- R6: An instruction with `in_has_dst`=0 leaves both the bindings and the pool unchanged. The next allocation returns the same register it would have returned without that instruction.
- R7: `in_ready` is 0 exactly when `in_has_dst`=1 and the pool is empty. Instructions with `in_has_dst`=0 are still accepted while the pool is empty. A release can be allocated from the cycle after it is presented.
- R8: A released register, presented on `rel_valid`/`rel_preg`, joins the tail of the pool. Registers are handed out again in the order in which they were released.
- R9: A release and an accepted allocation in the same cycle both take effect. The allocation takes the old head, and the released register lands behind every register already in the pool.
- R10: An instruction accepted at a clock edge (`in_valid` and `in_ready` both 1) appears with `out_valid`=1 immediately after that edge. `out_valid` is 0 in every cycle that follows an edge with no acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Stage can accept the instruction |
| in_src_a | input | 3 | First source architectural name |
| in_src_b | input | 3 | Second source architectural name |
| in_dst | input | 3 | Destination architectural name |
| in_has_dst | input | 1 | Instruction writes `in_dst` |
| out_valid | output | 1 | Renamed instruction present |
| out_src_a_p | output | 4 | Physical register for the first source |
| out_src_b_p | output | 4 | Physical register for the second source |
| out_dst_p | output | 4 | Newly allocated destination register |
| out_old_p | output | 4 | Previous binding of the destination |
| out_has_dst | output | 1 | Copy of `in_has_dst` |
| rel_valid | input | 1 | A physical register is being returned |
| rel_preg | input | 4 | Register being returned |

## Verification
Suppose a binding in the table is corrupt. The next instruction that reads that name shows it on a source field one cycle after acceptance. If a later instruction writes that name, the wrong value shows up on `out_old_p` instead. A pool that lost, duplicated or reordered an entry only shows up at the next allocation that reaches that slot. That can be up to eight allocations later. For this reason the stimulus drains the pool to empty more than once, and it cycles released registers all the way round. A miscounted pool shows up at once, as `in_ready` falling too early or rising too late.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int RN_ARCH_REGS = 8;
  localparam int RN_PHYS_REGS = 16;

  typedef enum logic [1:0] {
    POOL_HOLD = 2'b00,
    POOL_POP  = 2'b01,
    POOL_PUSH = 2'b10,
    POOL_BOTH = 2'b11
  } pool_op_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 8,
  parameter int PW        = 4,
  localparam int AW       = $clog2(ARCH_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  input  logic [AW-1:0] rd_d_idx,
  output logic [PW-1:0] rd_a_val,
  output logic [PW-1:0] rd_b_val,
  output logic [PW-1:0] rd_d_val,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_val
);
  logic [PW-1:0] bind_q [ARCH_REGS];
  logic [PW-1:0] bind_d [ARCH_REGS];

  always_comb begin
    rd_a_val = bind_q[rd_a_idx];
    rd_b_val = bind_q[rd_b_idx];
    rd_d_val = bind_q[rd_d_idx];
  end

  always_comb begin
    for (int i = 0; i < ARCH_REGS; i++) bind_d[i] = bind_q[i];
    if (wr_en) bind_d[wr_idx] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) bind_q[i] <= PW'(i);
    end else if (wr_en) begin
      for (int i = 0; i < ARCH_REGS; i++) bind_q[i] <= bind_d[i];
    end
  end

  assert_map_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bind_q[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool
  import rename_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PW        = 4,
  parameter int INIT_CNT  = 8,
  parameter int INIT_BASE = 8,
  localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_val,
  output logic [PW-1:0] head_val,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [PW-1:0] slot_q [DEPTH];
  logic [IW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  pool_op_e      op;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign op       = pool_op_e'({push, pop});
  assign head_val = slot_q[head_q];
  assign empty    = (cnt_q == '0);
  assign count    = cnt_q;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    unique case (op)
      POOL_POP:  begin head_d = wrap_inc(head_q); cnt_d = cnt_q - 1'b1; end
      POOL_PUSH: begin tail_d = wrap_inc(tail_q); cnt_d = cnt_q + 1'b1; end
      POOL_BOTH: begin head_d = wrap_inc(head_q); tail_d = wrap_inc(tail_q); end
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= IW'(INIT_CNT % DEPTH);
      cnt_q  <= CW'(INIT_CNT);
    end else if (push || pop) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= (g < INIT_CNT) ? PW'(INIT_BASE + g) : '0;
      else if (push && tail_q == IW'(g))
        slot_q[g] <= push_val;
    end
  end

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q != CW'(DEPTH));
  assert_count_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt_q));
endmodule

// File: rtl/reg_rename.sv
module reg_rename
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = RN_ARCH_REGS,
  parameter int PHYS_REGS = RN_PHYS_REGS,
  localparam int AW       = $clog2(ARCH_REGS),
  localparam int PW       = $clog2(PHYS_REGS),
  localparam int FREE0    = PHYS_REGS - ARCH_REGS,
  localparam int CW       = $clog2(PHYS_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic [AW-1:0] in_dst,
  input  logic          in_has_dst,
  output logic          out_valid,
  output logic [PW-1:0] out_src_a_p,
  output logic [PW-1:0] out_src_b_p,
  output logic [PW-1:0] out_dst_p,
  output logic [PW-1:0] out_old_p,
  output logic          out_has_dst,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_preg
);
  logic [PW-1:0] src_a_p, src_b_p, prev_p, fresh_p;
  logic          pool_empty, accept, alloc;
  logic [CW-1:0] pool_cnt;

  assign in_ready = !in_has_dst || !pool_empty;
  assign accept   = in_valid && in_ready;
  assign alloc    = accept && in_has_dst;

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PW(PW)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(in_src_a), .rd_b_idx(in_src_b), .rd_d_idx(in_dst),
    .rd_a_val(src_a_p), .rd_b_val(src_b_p), .rd_d_val(prev_p),
    .wr_en(alloc), .wr_idx(in_dst), .wr_val(fresh_p)
  );

  rn_free_pool #(.DEPTH(PHYS_REGS), .PW(PW), .INIT_CNT(FREE0), .INIT_BASE(ARCH_REGS)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc), .push(rel_valid), .push_val(rel_preg),
    .head_val(fresh_p), .empty(pool_empty), .count(pool_cnt)
  );

  logic          vld_q;
  logic [PW-1:0] a_q, b_q, d_q, o_q;
  logic          hd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; d_q <= '0; o_q <= '0; hd_q <= 1'b0;
    end else if (accept) begin
      a_q  <= src_a_p;
      b_q  <= src_b_p;
      d_q  <= in_has_dst ? fresh_p : '0;
      o_q  <= in_has_dst ? prev_p  : '0;
      hd_q <= in_has_dst;
    end
  end

  assign out_valid   = vld_q;
  assign out_src_a_p = a_q;
  assign out_src_b_p = b_q;
  assign out_dst_p   = d_q;
  assign out_old_p   = o_q;
  assign out_has_dst = hd_q;

  assert_fresh_differs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> fresh_p != prev_p);
  assert_stall_only_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (in_has_dst && pool_cnt == '0));
  assert_output_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
endmodule

// File: tb/reg_rename_tb.sv
module reg_rename_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_has_dst;
  logic [2:0] in_src_a, in_src_b, in_dst;
  logic       out_valid, out_has_dst;
  logic [3:0] out_src_a_p, out_src_b_p, out_dst_p, out_old_p;
  logic       rel_valid;
  logic [3:0] rel_preg;

  always #2.5 clk = ~clk;

  reg_rename u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_has_dst(in_has_dst),
    .out_valid(out_valid), .out_src_a_p(out_src_a_p), .out_src_b_p(out_src_b_p),
    .out_dst_p(out_dst_p), .out_old_p(out_old_p), .out_has_dst(out_has_dst),
    .rel_valid(rel_valid), .rel_preg(rel_preg)
  );

  typedef struct { int a; int b; int d; int o; bit hd; string tag; } exp_t;

  int   checks = 0;
  int   errors = 0;
  int   mdl_map [8];
  int   mdl_free [$];
  int   relq [$];
  exp_t expq [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compare every renamed output against the scoreboard queue (R2..R5, R10)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R10 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(out_src_a_p == 4'(e.a), {e.tag, " src_a"}, int'(out_src_a_p), e.a);
        check(out_src_b_p == 4'(e.b), {e.tag, " src_b"}, int'(out_src_b_p), e.b);
        check(out_has_dst == e.hd, {e.tag, " has_dst"}, int'(out_has_dst), int'(e.hd));
        if (e.hd) begin
          check(out_dst_p == 4'(e.d), {e.tag, " R4 dst"}, int'(out_dst_p), e.d);
          check(out_old_p == 4'(e.o), {e.tag, " R5 old"}, int'(out_old_p), e.o);
        end
      end
    end
  end

  task automatic idle_inputs();
    in_valid = 0; in_has_dst = 0; in_src_a = 0; in_src_b = 0; in_dst = 0;
    rel_valid = 0; rel_preg = 0;
  endtask

  // Driver: present one instruction (optionally with a release) and score it
  task automatic issue(input int sa, input int sb, input int sd, input bit hd,
                       input bit do_rel, input string tag);
    bit   rel_now, exp_rdy;
    int   rp;
    exp_t e;
    @(negedge clk);
    rel_now = do_rel && (relq.size() > 0);
    rp = rel_now ? relq[0] : 0;
    in_valid = 1; in_src_a = 3'(sa); in_src_b = 3'(sb); in_dst = 3'(sd); in_has_dst = hd;
    rel_valid = rel_now; rel_preg = 4'(rp);
    #1;
    exp_rdy = !hd || (mdl_free.size() != 0);
    check(in_ready == exp_rdy, {tag, " R7 in_ready"}, int'(in_ready), int'(exp_rdy));
    if (in_ready && exp_rdy) begin
      e.a = mdl_map[sa]; e.b = mdl_map[sb]; e.hd = hd; e.tag = tag; e.d = 0; e.o = 0;
      if (rel_now) void'(relq.pop_front());
      if (hd) begin
        e.d = mdl_free.pop_front();
        e.o = mdl_map[sd];
        mdl_map[sd] = e.d;
        relq.push_back(e.o);
      end
      if (rel_now) mdl_free.push_back(rp);
      expq.push_back(e);
    end else begin
      in_valid = 0;
      if (rel_now) begin void'(relq.pop_front()); mdl_free.push_back(rp); end
    end
    @(posedge clk);
    #1 idle_inputs();
  endtask

  task automatic release_only();
    int rp;
    @(negedge clk);
    rp = relq.pop_front();
    rel_valid = 1; rel_preg = 4'(rp);
    mdl_free.push_back(rp);
    @(posedge clk);
    #1 idle_inputs();
  endtask

  task automatic expect_stall(input string tag);
    @(negedge clk);
    in_valid = 1; in_has_dst = 1; in_dst = 3'd4; in_src_a = 3'd1; in_src_b = 3'd2;
    #1;
    check(in_ready == 1'b0, {tag, " R7 stall when empty"}, int'(in_ready), 0);
    @(posedge clk);
    #1 idle_inputs();
    @(negedge clk);
    check(out_valid == 1'b0, {tag, " R10 no output after stall"}, int'(out_valid), 0);
  endtask

  initial begin
    int lcg;
    idle_inputs();
    for (int i = 0; i < 8; i++) mdl_map[i] = i;
    for (int i = 8; i < 16; i++) mdl_free.push_back(i);
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    in_has_dst = 1; #1;
    check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    in_has_dst = 0;

    issue(3, 4, 2, 1, 0, "R1 first alloc head=8");
    issue(2, 1, 0, 0, 0, "R2 read new binding / R6 store");
    issue(1, 1, 1, 1, 0, "R3 read-before-write");
    issue(5, 6, 7, 0, 0, "R6 no-dst");
    issue(2, 7, 5, 1, 0, "R6 next alloc unchanged");
    for (int i = 0; mdl_free.size() > 0; i++)
      issue(i % 8, (i + 3) % 8, (i * 5) % 8, 1, 0, "R4 drain pool");
    expect_stall("R7 empty pool");
    issue(1, 2, 3, 0, 0, "R7 no-dst accepted while empty");
    expect_stall("R7 still empty");
    release_only();
    issue(2, 3, 6, 1, 0, "R8 reuse released register");
    release_only();
    release_only();
    issue(6, 6, 6, 1, 1, "R9 alloc and release same cycle");
    issue(0, 6, 3, 1, 0, "R9 second from pool");
    issue(4, 5, 0, 1, 0, "R9 released register at tail");
    lcg = 7;
    for (int i = 0; i < 80; i++) begin
      bit hd;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      hd = (lcg[4:3] != 2'b00) && (mdl_free.size() != 0);
      issue(lcg[10:8], lcg[13:11], lcg[16:14], hd, lcg[18] || relq.size() > 6, "R8 mixed stream");
    end
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R10 all outputs seen", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule